// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter for a microcontroller-class subsystem. It advances on an instruction-rate enable, which runs at one quarter of the system clock. A selectable prescaler sits in front of the counter. The counter climbs until it equals a programmable period value, and on the following advance it returns to zero.

Every such wrap is a period match. The match is exported as a one-clock pulse that a serial-port shift-clock generator can use. Each match is also counted by a 4-bit postscaler, and when the postscaler reaches its programmed count of matches it sets a sticky interrupt flag.

Software uses a small register bus to read and write the count, the period and the control byte, and to clear the flag.

Register map, selected by `bus_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | count | the counter value |
| 1 | period | the wrap value |
| 2 | control | bit 7 always reads 0; bits 6:3 postscale select; bit 2 enable; bits 1:0 prescale select |
| 3 | status | bit 0 is the flag; the other bits read 0 |

Top module: `period_timer`

## Requirements
- R1: After reset the registers hold these values: count 00h, period FFh, control 00h, flag 0. `match_pulse` is 0.
- R2: Each advance adds one to the count. When the count equals the period, the next advance loads 00h instead. `match_pulse` is 1 for exactly the clock cycle that follows the edge on which the count wrapped to 00h, and 0 otherwise.
- R3: The counter advances only while `inst_tick` is 1 and the enable bit (control bit 2) is 1. With the enable bit at 0 the count holds, whatever `inst_tick` does.
- R4: Control bits 1:0 set how many `inst_tick` cycles make one advance: 00 gives 1, 01 gives 4, and 10 or 11 gives 16.
- R5: A postscale field value n (control bits 6:3) sets the flag on every (n+1)-th period match, so field 0000 sets it on every match and field 1111 on every sixteenth.
- R6: Reads are combinational from `bus_addr` as listed in the register map. Control bit 7 always reads 0, even after a write of 1 to it.
- R7: A write to the count register or to the control register clears both the prescale counter and the postscale counter.
- R8: A write to the control register leaves the count register unchanged.
- R9: The flag stays set until software writes to address 3 with data bit 0 at 1. When that clear and a new postscaler set fall in the same cycle, the flag ends up set.
- R10: A write to the count register takes priority over an advance in the same cycle. The written value is loaded, and no match pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_tick | input | 1 | Instruction-rate enable, one cycle in four of the system clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_flag | output | 1 | Sticky interrupt flag |
| match_pulse | output | 1 | One-clock period-match pulse, taken before the postscaler |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is a flag clear from software and a postscaler terminal count. The bench sets up a period of zero with postscale 1:1, so every advance is a match. It then raises the first `inst_tick` in the same cycle as a status write of 1. The flag must read 1 afterwards, and a later lone clear must bring it to 0.

The second pair is a count write and an advance that would wrap. The bench parks the count on the period value and writes a different count as a tick arrives. It then expects exactly the written value, with `match_pulse` low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DW        = 8;   // register and counter width
    localparam int PRE_SELW  = 2;   // prescale select width
    localparam int POST_W    = 4;   // postscale counter width
    localparam int ADR_W     = 2;
    localparam int EN_BIT    = 2;
    localparam int PRE_LSB   = 0;
    localparam int POST_LSB  = 3;
    localparam logic [DW-1:0] CTRL_MASK = 8'h7F;

    typedef enum logic [ADR_W-1:0] {
        A_COUNT  = 2'd0,
        A_PERIOD = 2'd1,
        A_CTRL   = 2'd2,
        A_STAT   = 2'd3
    } tmr_addr_e;

    typedef struct packed {
        logic [DW-1:0] count;
        logic [DW-1:0] period;
        logic [DW-1:0] ctrl;
        logic          flag;
        logic          match;
    } tmr_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick_en,
    input  logic [SELW-1:0] sel,
    output logic            adv
);
    // each select step multiplies the division by four, saturating at 1:16
    localparam int MAXSTEP = 2;
    localparam int PW      = 2 * MAXSTEP;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] limit;

    always_comb begin
        if (sel == '0)
            limit = '0;
        else if (sel == SELW'(1))
            limit = PW'(3);
        else
            limit = '1;
    end

    always_comb begin
        cnt_d = cnt_q;
        adv   = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (tick_en) begin
            if (cnt_q >= limit) begin
                cnt_d = '0;
                adv   = 1'b1;
            end else begin
                cnt_d = cnt_q + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         event_i,
    input  logic [W-1:0] sel,
    output logic         fire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (event_i) begin
            if (cnt_q >= sel) begin
                cnt_d = '0;
                fire  = 1'b1;
            end else begin
                cnt_d = cnt_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/period_timer.sv
module period_timer
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_tick,
    input  logic             bus_we,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_flag,
    output logic             match_pulse
);
    tmr_state_t r_d, r_q;

    logic wr_cnt, wr_per, wr_ctrl, wr_stat;
    logic scl_clr, adv, hit, wrap, fire;

    assign wr_cnt  = bus_we && (bus_addr == A_COUNT);
    assign wr_per  = bus_we && (bus_addr == A_PERIOD);
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_stat = bus_we && (bus_addr == A_STAT);
    assign scl_clr = wr_cnt || wr_ctrl;

    tmr_prescaler #(.SELW(PRE_SELW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (scl_clr),
        .tick_en (inst_tick && r_q.ctrl[EN_BIT]),
        .sel     (r_q.ctrl[PRE_LSB +: PRE_SELW]),
        .adv     (adv)
    );

    tmr_postscaler #(.W(POST_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (scl_clr),
        .event_i (wrap),
        .sel     (r_q.ctrl[POST_LSB +: POST_W]),
        .fire    (fire)
    );

    assign hit  = (r_q.count == r_q.period);
    assign wrap = adv && !wr_cnt && hit;

    always_comb begin
        r_d       = r_q;
        r_d.match = wrap;
        if (wr_cnt)
            r_d.count = bus_wdata;
        else if (adv)
            r_d.count = hit ? '0 : r_q.count + DW'(1);
        if (wr_per)
            r_d.period = bus_wdata;
        if (wr_ctrl)
            r_d.ctrl = bus_wdata & CTRL_MASK;
        r_d.flag = fire || (r_q.flag && !(wr_stat && bus_wdata[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.count  <= '0;
            r_q.period <= '1;
            r_q.ctrl   <= '0;
            r_q.flag   <= 1'b0;
            r_q.match  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_COUNT:  bus_rdata = r_q.count;
            A_PERIOD: bus_rdata = r_q.period;
            A_CTRL:   bus_rdata = r_q.ctrl;
            default:  bus_rdata = {{(DW-1){1'b0}}, r_q.flag};
        endcase
    end

    assign irq_flag    = r_q.flag;
    assign match_pulse = r_q.match;
endmodule

module period_timer_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [ADR_W-1:0] bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic             irq_flag,
    input logic             match_pulse,
    input logic [DW-1:0]    cnt,
    input logic [DW-1:0]    ctrl
);
    // R2: a match pulse always shows a freshly wrapped count
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (cnt == '0));

    // R3: with the enable bit clear and no count write, the count holds
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[EN_BIT] && !(bus_we && bus_addr == A_COUNT)) |=> $stable(cnt));

    // R6: control bit 7 never reads back as 1
    a_r6_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> !bus_rdata[DW-1]);

    // R8: a control write leaves the count alone
    a_r8_ctrl_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=> $stable(cnt));

    // R9: without a clear the flag stays set
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(bus_we && bus_addr == A_STAT && bus_wdata[0])) |=> irq_flag);

    // R10: a count write lands exactly and raises no match
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_COUNT) |=> (cnt == $past(bus_wdata) && !match_pulse));
endmodule

bind period_timer period_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_flag    (irq_flag),
    .match_pulse (match_pulse),
    .cnt         (r_q.count),
    .ctrl        (r_q.ctrl)
);

// File: tb/period_timer_test.sv
module period_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inst_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_flag;
    logic       match_pulse;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .inst_tick   (inst_tick),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_flag    (irq_flag),
        .match_pulse (match_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // advance n edges and land on the following falling edge
    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 count", 2'd0, 8'h00);
        rd_check("R1 period", 2'd1, 8'hFF);
        rd_check("R1 ctrl", 2'd2, 8'h00);
        rd_check("R1 status", 2'd3, 8'h00);
        check("R1 match", {7'd0, match_pulse}, 8'h00);
    endtask

    task automatic t_disabled;
        inst_tick = 1'b1;
        run(10);
        inst_tick = 1'b0;
        rd_check("R3 off holds", 2'd0, 8'h00);
    endtask

    task automatic t_bit7;
        wr(2'd2, 8'hFF);
        rd_check("R6 bit7 reads 0", 2'd2, 8'h7F);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_wrap;
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h00);
        inst_tick = 1'b1;
        run(3);
        check("R2 count at period", bus_rdata, 8'h03);
        check("R2 no early match", {7'd0, match_pulse}, 8'h00);
        run(1);
        check("R2 wrapped count", bus_rdata, 8'h00);
        check("R2 match high", {7'd0, match_pulse}, 8'h01);
        check("R5 flag at 1:1", {7'd0, irq_flag}, 8'h01);
        run(1);
        check("R2 match one cycle", {7'd0, match_pulse}, 8'h00);
        check("R2 count after wrap", bus_rdata, 8'h01);
        inst_tick = 1'b0;
        run(5);
        check("R9 flag sticky", {7'd0, irq_flag}, 8'h01);
        wr(2'd3, 8'h01);
        check("R9 flag cleared", {7'd0, irq_flag}, 8'h00);
    endtask

    task automatic t_sparse_tick;
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 4; i++) begin
            inst_tick = 1'b1;
            run(1);
            inst_tick = 1'b0;
            run(3);
        end
        rd_check("R3 sparse ticks", 2'd0, 8'h04);
    endtask

    task automatic t_prescale;
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h00);
        bus_addr = 2'd0;
        inst_tick = 1'b1;
        run(3);
        check("R4 1:4 before", bus_rdata, 8'h00);
        run(1);
        check("R4 1:4 first", bus_rdata, 8'h01);
        run(4);
        check("R4 1:4 second", bus_rdata, 8'h02);
        inst_tick = 1'b0;
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h00);
        bus_addr = 2'd0;
        inst_tick = 1'b1;
        run(15);
        check("R4 1:16 before", bus_rdata, 8'h00);
        run(1);
        check("R4 1:16 first", bus_rdata, 8'h01);
        inst_tick = 1'b0;
    endtask

    task automatic t_scaler_clear;
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h00);
        bus_addr = 2'd0;
        inst_tick = 1'b1;
        run(3);
        inst_tick = 1'b0;
        wr(2'd0, 8'h05);
        bus_addr = 2'd0;
        inst_tick = 1'b1;
        run(3);
        check("R7 count write clears prescale", bus_rdata, 8'h05);
        run(1);
        check("R7 advance after 4", bus_rdata, 8'h06);
        run(2);
        inst_tick = 1'b0;
        wr(2'd2, 8'h05);
        rd_check("R8 ctrl write keeps count", 2'd0, 8'h06);
        inst_tick = 1'b1;
        run(3);
        check("R7 ctrl write clears prescale", bus_rdata, 8'h06);
        run(1);
        check("R7 advance after ctrl write", bus_rdata, 8'h07);
        inst_tick = 1'b0;
    endtask

    task automatic t_postscale;
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h14);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h01);
        inst_tick = 1'b1;
        run(5);
        check("R5 1:3 before", {7'd0, irq_flag}, 8'h00);
        run(1);
        check("R5 1:3 third match", {7'd0, irq_flag}, 8'h01);
        inst_tick = 1'b0;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h7C);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h01);
        inst_tick = 1'b1;
        run(15);
        check("R5 1:16 before", {7'd0, irq_flag}, 8'h00);
        check("R2 match at period 0", {7'd0, match_pulse}, 8'h01);
        run(1);
        check("R5 1:16 sixteenth", {7'd0, irq_flag}, 8'h01);
        inst_tick = 1'b0;
    endtask

    task automatic t_set_wins;
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h00);
        inst_tick = 1'b1;
        bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h01;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        inst_tick = 1'b0;
        check("R9 set beats clear", {7'd0, irq_flag}, 8'h01);
        wr(2'd3, 8'h01);
        check("R9 lone clear", {7'd0, irq_flag}, 8'h00);
    endtask

    task automatic t_write_priority;
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h03);
        inst_tick = 1'b1;
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h02;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        inst_tick = 1'b0;
        #1;
        check("R10 written value", bus_rdata, 8'h02);
        check("R10 no match", {7'd0, match_pulse}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_bit7();
        t_wrap();
        t_sparse_tick();
        t_prescale();
        t_scaler_clear();
        t_postscale();
        t_set_wins();
        t_write_priority();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule